// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is a synchronous slave for a host bus whose eight shared lines carry the address first and the data afterwards. An address-latch strobe from the host marks the address phase. The block captures the address on the falling clock edge while that strobe is high. In byte-lane mode, the two byte-enable pins stand in for the two lowest address bits. The host then pulls an active-low address/data strobe. If both chip selects are active when the block samples that strobe on a rising edge, a transaction opens.

On the user side the block presents the address, a read/write flag (high means read) and a one-cycle start pulse. It then holds the host in wait states until user logic answers with an end input. For a write, the block captures the data from the shared lines one cycle after the strobe. For a read, it captures the user data together with the end signal and drives it onto the shared lines. That happens only in the single cycle in which the active-low ready/recover acknowledge is low.

Top module: `muxbus_slave`

## Requirements
- R1: The address is taken from shared-bus bits 4:0 on the falling clock edge while `hostAle` is high. While `hostAle` is low, later bus values do not change it.
- R2: In byte-lane mode (default, `BYTE_LANE_ADDR=1`), address bit 0 is the level of pin `hostBe0N` and address bit 1 is the level of pin `hostBe1N`. These replace bus bits 1:0.
- R3: A transaction opens when the idle block samples `hostAdsN` low on a rising edge. `userStart` goes high for exactly one cycle, the second cycle after that edge.
- R4: `userAddr` shows the latched address. `userRdWr` is the inverse of `hostWrRd`: the host line is 1 for write, and `userRdWr` is 1 for read.
- R5: Write data is sampled from the shared bus on the rising edge one cycle after the strobe edge. It appears on `userWrData` while `userStart` is high.
- R6: `hostRdyN` is low for exactly one clock cycle per transaction.
- R7: The acknowledge cycle follows the cycle in which `userEnd` is first seen high (during or after the start cycle). With user delay d, it is the (3+d)-th cycle after the strobe edge.
- R8: On a read, `hostAdOut` in the acknowledge cycle equals `userRdData` as sampled with `userEnd`.
- R9: `hostAdOe` is high only in the acknowledge cycle of a read. It is low on writes and at all other times.
- R10: A strobe is ignored, with no start and no acknowledge, unless `hostCsN` is low and `hostCs` is high.
- R11: After reset, `hostRdyN` is high and `hostAdOe` and `userStart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAdIn | input | 8 | Shared address/data lines, inbound |
| hostAdOut | output | 8 | Shared lines, outbound read data |
| hostAdOe | output | 1 | Drive enable for the shared lines |
| hostAle | input | 1 | Address latch enable, active high |
| hostAdsN | input | 1 | Address/data strobe, active low |
| hostBe0N | input | 1 | Byte enable 0, address bit 0 in byte-lane mode |
| hostBe1N | input | 1 | Byte enable 1, address bit 1 in byte-lane mode |
| hostWrRd | input | 1 | 1 = write, 0 = read |
| hostCsN | input | 1 | Chip select, active low |
| hostCs | input | 1 | Chip select, active high |
| hostRdyN | output | 1 | Ready/recover acknowledge, active low |
| userAddr | output | 5 | Latched transaction address |
| userRdWr | output | 1 | 1 = read, 0 = write |
| userStart | output | 1 | One-cycle start pulse |
| userEnd | input | 1 | User logic done |
| userWrData | output | 8 | Write data to user logic |
| userRdData | input | 8 | Read data from user logic |

## Verification
The hardest case to reach from the ports is a user end that arrives in the same cycle as the start pulse. That path skips the wait state entirely, so the bench feeds `userStart` straight back into `userEnd`. A negedge-driven counter supplies end delays of one to three cycles. The sweep also covers every address with both directions. Each byte-enable pin is set opposite to the matching bus bit, and the bus is overwritten after the latch edge. Any mix-up in address capture therefore shows up in `userAddr`.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_START,
    ST_WAIT,
    ST_ACK
  } busState_t;

  typedef struct packed {
    logic loadTxn;
    logic loadWr;
    logic loadRd;
  } dpStrobe_t;
endpackage

// File: rtl/muxbus_dp.sv
module muxbus_dp
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter bit BYTE_LANE_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostAdIn,
  input  logic              hostAle,
  input  logic              hostBe0N,
  input  logic              hostBe1N,
  input  logic              hostWrRd,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] userRdData,
  output logic [ADDR_W-1:0] userAddr,
  output logic              isRead,
  output logic [DATA_W-1:0] userWrData,
  output logic [DATA_W-1:0] hostRdData
);
  logic [ADDR_W-1:0] busAddr;
  logic [ADDR_W-1:0] latchAddr;

  generate
    if (BYTE_LANE_ADDR) begin : g_byteLane
      assign busAddr = {hostAdIn[ADDR_W-1:2], hostBe1N, hostBe0N};
    end else begin : g_busLane
      assign busAddr = hostAdIn[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) latchAddr <= '0;
    else if (hostAle) latchAddr <= busAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userAddr   <= '0;
      isRead     <= 1'b0;
      userWrData <= '0;
      hostRdData <= '0;
    end else begin
      if (strobe.loadTxn) begin
        userAddr <= latchAddr;
        isRead   <= ~hostWrRd;
      end
      if (strobe.loadWr) userWrData <= hostAdIn;
      if (strobe.loadRd) hostRdData <= userRdData;
    end
  end
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostAdsN,
  input  logic      hostCsN,
  input  logic      hostCs,
  input  logic      userEnd,
  input  logic      isRead,
  output dpStrobe_t strobe,
  output logic      userStart,
  output logic      hostRdyN,
  output logic      hostAdOe
);
  busState_t state, nextState;
  logic selected;

  assign selected = ~hostCsN & hostCs;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (selected && !hostAdsN) begin
          nextState      = ST_CAPT;
          strobe.loadTxn = 1'b1;
        end
      end
      ST_CAPT: begin
        nextState     = ST_START;
        strobe.loadWr = 1'b1;
      end
      ST_START, ST_WAIT: begin
        if (userEnd) begin
          nextState     = ST_ACK;
          strobe.loadRd = 1'b1;
        end else begin
          nextState = ST_WAIT;
        end
      end
      ST_ACK:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign userStart = (state == ST_START);
  assign hostRdyN  = (state != ST_ACK);
  assign hostAdOe  = (state == ST_ACK) & isRead;
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter bit BYTE_LANE_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostAdIn,
  output logic [DATA_W-1:0] hostAdOut,
  output logic              hostAdOe,
  input  logic              hostAle,
  input  logic              hostAdsN,
  input  logic              hostBe0N,
  input  logic              hostBe1N,
  input  logic              hostWrRd,
  input  logic              hostCsN,
  input  logic              hostCs,
  output logic              hostRdyN,
  output logic [ADDR_W-1:0] userAddr,
  output logic              userRdWr,
  output logic              userStart,
  input  logic              userEnd,
  output logic [DATA_W-1:0] userWrData,
  input  logic [DATA_W-1:0] userRdData
);
  dpStrobe_t strobe;
  logic isRead;

  muxbus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostAdsN (hostAdsN),
    .hostCsN  (hostCsN),
    .hostCs   (hostCs),
    .userEnd  (userEnd),
    .isRead   (isRead),
    .strobe   (strobe),
    .userStart(userStart),
    .hostRdyN (hostRdyN),
    .hostAdOe (hostAdOe)
  );

  muxbus_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BYTE_LANE_ADDR(BYTE_LANE_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostAdIn  (hostAdIn),
    .hostAle   (hostAle),
    .hostBe0N  (hostBe0N),
    .hostBe1N  (hostBe1N),
    .hostWrRd  (hostWrRd),
    .strobe    (strobe),
    .userRdData(userRdData),
    .userAddr  (userAddr),
    .isRead    (isRead),
    .userWrData(userWrData),
    .hostRdData(hostAdOut)
  );

  assign userRdWr = isRead;
endmodule

// File: rtl/muxbus_slave_chk.sv
module muxbus_slave_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAdsN,
  input logic              hostCsN,
  input logic              hostCs,
  input logic              hostRdyN,
  input logic              hostAdOe,
  input logic              userStart,
  input logic              userEnd,
  input logic              userRdWr,
  input logic [ADDR_W-1:0] userAddr
);
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdyN |=> hostRdyN);

  a_r9_oe_read_ack: assert property (@(posedge clk) disable iff (!rstN)
    hostAdOe |-> (!hostRdyN && userRdWr));

  a_r7_ack_after_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRdyN) |-> $past(userEnd));

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    userStart |=> !userStart);

  a_r10_start_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userStart) |-> $past(!hostAdsN && !hostCsN && hostCs, 2));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    userStart |=> ($stable(userAddr) && $stable(userRdWr)));

  a_r11_reset_idle: assert property (@(posedge clk)
    !rstN |-> (hostRdyN && !hostAdOe && !userStart));
endmodule

bind muxbus_slave muxbus_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostAdsN (hostAdsN),
  .hostCsN  (hostCsN),
  .hostCs   (hostCs),
  .hostRdyN (hostRdyN),
  .hostAdOe (hostAdOe),
  .userStart(userStart),
  .userEnd  (userEnd),
  .userRdWr (userRdWr),
  .userAddr (userAddr)
);

// File: tb/tb_muxbus_slave.sv
module tb_muxbus_slave;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] hostAdIn = 8'h00;
  logic [7:0] hostAdOut;
  logic       hostAdOe;
  logic       hostAle = 1'b0;
  logic       hostAdsN = 1'b1;
  logic       hostBe0N = 1'b1;
  logic       hostBe1N = 1'b1;
  logic       hostWrRd = 1'b0;
  logic       hostCsN = 1'b1;
  logic       hostCs = 1'b0;
  logic       hostRdyN;
  logic [4:0] userAddr;
  logic       userRdWr;
  logic       userStart;
  logic       userEnd;
  logic [7:0] userWrData;
  logic [7:0] userRdData;

  int total = 0;
  int bad = 0;
  int cfgDelay = 0;
  int endCnt = 0;
  bit endArmed = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  muxbus_slave dut (
    .clk(clk), .rstN(rstN), .hostAdIn(hostAdIn), .hostAdOut(hostAdOut),
    .hostAdOe(hostAdOe), .hostAle(hostAle), .hostAdsN(hostAdsN),
    .hostBe0N(hostBe0N), .hostBe1N(hostBe1N), .hostWrRd(hostWrRd),
    .hostCsN(hostCsN), .hostCs(hostCs), .hostRdyN(hostRdyN),
    .userAddr(userAddr), .userRdWr(userRdWr), .userStart(userStart),
    .userEnd(userEnd), .userWrData(userWrData), .userRdData(userRdData)
  );

  function automatic logic [7:0] rdPattern(input logic [4:0] a);
    return 8'(a * 37 + 11);
  endfunction

  // user logic model: end after cfgDelay cycles past the start cycle
  assign userEnd    = (cfgDelay == 0) ? userStart : (endArmed && endCnt == 0);
  assign userRdData = rdPattern(userAddr);

  always @(negedge clk) begin
    if (userStart) begin
      endCnt   <= cfgDelay;
      endArmed <= (cfgDelay != 0);
    end else if (endArmed) begin
      if (endCnt == 0) endArmed <= 1'b0;
      else endCnt <= endCnt - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putAddress(input logic [4:0] a, input bit csNv, input bit csv, input bit wr);
    @(posedge clk); #1;
    hostAle  = 1'b1;
    hostAdIn = {3'b101, a[4:2], ~a[1:0]};
    hostBe1N = a[1];
    hostBe0N = a[0];
    hostCsN  = csNv;
    hostCs   = csv;
    hostWrRd = wr;
    @(posedge clk); #1;
    hostAle  = 1'b0;
    hostAdsN = 1'b0;
    hostAdIn = ~{3'b000, a};
  endtask

  task automatic runTxn(input logic [4:0] a, input bit wr, input logic [7:0] wd, input int d);
    int n = 0;
    int startAt = -1;
    int starts = 0;
    cfgDelay = d;
    putAddress(a, 1'b0, 1'b1, wr);
    @(posedge clk); #1;
    hostAdsN = 1'b1;
    hostAdIn = wd;
    while (n < 20) begin
      @(negedge clk);
      n++;
      if (userStart) begin
        starts++;
        startAt = n;
      end
      if (!hostRdyN) break;
    end
    check(startAt == 2 && starts == 1, "R3 start pulse position", startAt, 2);
    check(n == 3 + d, "R7 ack latency", n, 3 + d);
    check(userAddr == a, "R1 R2 latched address", userAddr, a);
    check(userRdWr == !wr, "R4 read/write flag", userRdWr, !wr);
    if (wr) begin
      check(userWrData == wd, "R5 write data", userWrData, wd);
      check(!hostAdOe, "R9 no drive on write", hostAdOe, 0);
    end else begin
      check(hostAdOe, "R9 drive on read ack", hostAdOe, 1);
      check(hostAdOut == rdPattern(a), "R8 read data", hostAdOut, rdPattern(a));
    end
    @(negedge clk);
    check(hostRdyN, "R6 ack one cycle", hostRdyN, 1);
    check(!hostAdOe, "R9 drive released", hostAdOe, 0);
  endtask

  task automatic tryIgnored(input bit csNv, input bit csv);
    int hits = 0;
    cfgDelay = 0;
    putAddress(5'h13, csNv, csv, 1'b1);
    @(posedge clk); #1;
    hostAdsN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (userStart || !hostRdyN || hostAdOe) hits++;
    end
    check(hits == 0, "R10 strobe ignored without selects", hits, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 3 + 2);
    check(hostRdyN && !hostAdOe && !userStart, "R11 reset outputs",
          {hostRdyN, hostAdOe, userStart}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(hostRdyN && !userStart, "R11 idle after reset", {hostRdyN, userStart}, 2'b10);

    for (int a = 0; a < 32; a++) begin
      for (int w = 0; w < 2; w++) begin
        runTxn(5'(a), w[0], 8'(a * 13 + w * 101 + 7), (a + w) % 4);
      end
    end

    tryIgnored(1'b1, 1'b1);
    tryIgnored(1'b0, 1'b0);
    tryIgnored(1'b1, 1'b0);

    runTxn(5'h1F, 1'b0, 8'h00, 0);
    runTxn(5'h00, 1'b1, 8'hFF, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule